// File: doc/BRIEF.md
# Ping-Pong Frame Receive Buffer

This block sits behind a 100 Mbit Ethernet receive MAC and holds incoming frames in two alternating packet banks. The MAC hands it a byte stream with start-of-frame and end-of-frame markers. Each accepted frame is written into a bank that holds no unreleased frame. The processor reads one bank at a time through a byte-addressed window, and the first frame byte sits at window offset 0. Because a completed frame stays in place until software releases it, code carried in a frame can run directly from the window.

A single 8-bit control/status register carries everything else. Software turns reception on, sees that a frame is waiting and which bank received it, and chooses which bank the window shows. Each bank also has a flag that tells whether it is occupied. Two sticky flags report dropped frames and truncated frames. Any write to the register acknowledges the interrupt and releases the bank the write did not select.

The usual service loop has four steps. Software polls for the waiting flag or takes the interrupt, copies the "last bank" bit into the "view" bit, and writes that value back with the enable bit set. It then processes the frame in the window while the MAC fills the other bank.

Top module: `pp_rx_buffer`

## Requirements
- R1: After reset the status register reads 8'h00 and `irq` is low.
- R2: Status bit 0 is the receive enable and is written from `reg_wdata[0]`. While it is 0, a start-of-frame beat is ignored: no bank is written, no flag changes, and the status stays as it was.
- R3: Byte k of an accepted frame is stored at offset k of its bank. Status bit 1, written from `reg_wdata[1]`, selects the bank shown in the read window (0 = bank 0, 1 = bank 1). `buf_rdata` shows the byte at `buf_addr` one clock after the address is presented.
- R4: On the end-of-frame beat of an accepted frame, several status bits change at the next clock edge. Bit 5 (frame waiting) sets and `irq` rises. Bit 2 takes the number of the bank that was filled. The occupied flag of that bank sets: bit 3 for bank 0, bit 4 for bank 1.
- R5: Once a frame completes, the next frame goes by preference to the other bank. After reset the preferred bank is bank 0.
- R6: A register write has four effects. It clears bit 5 (and `irq`), bit 6 and bit 7. It loads bits 0 and 1. It releases the bank not selected by `reg_wdata[1]`, clearing that bank's occupied flag. The occupied flag of the selected bank is left unchanged.
- R7: An occupied bank is never written. If the preferred bank is occupied and the other bank is free, the frame goes into the free bank.
- R8: If both banks are occupied when a frame starts, the frame is dropped whole, both banks keep their contents, and status bit 6 (overflow) sets.
- R9: If a frame is longer than `BUF_BYTES`, only its first `BUF_BYTES` bytes are stored, with no wrap. The frame still completes as in R4, and status bit 7 (truncated) sets.
- R10: If a register write and a frame completion fall in the same cycle, the completion wins for the pending flag and for the occupied flag of the filled bank.
- R11: A frame of one byte, with start and end of frame on the same beat, is stored and completes as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | This beat carries the first byte of a frame |
| rx_eof | input | 1 | This beat carries the last byte of a frame |
| reg_wr | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Register write data (bit 0 enable, bit 1 view select) |
| reg_rdata | output | 8 | Status: 0 enable, 1 view, 2 last bank, 3/4 bank occupied, 5 waiting, 6 overflow, 7 truncated |
| buf_addr | input | AW | Byte offset into the visible bank |
| buf_rdata | output | 8 | Byte at `buf_addr`, one clock later |
| irq | output | 1 | High while a frame is waiting |

## Verification
The embedded properties watch the rules that can be judged from one or two cycles on every clock edge. These are: no write to an occupied bank, drops happen only when both banks are taken, the enable gates frame starts, a completion raises the waiting flag and names the right bank, and a plain write clears the flags and frees the unselected bank. Only the directed scenarios can show the rest. That covers the stored byte values and their offsets, the alternation of banks over a series of frames, the fallback when the preferred bank is held, the cut-off with no wrap on an oversized frame, and the outcome when a write lands on the end-of-frame beat.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

    // Control/status register layout
    localparam int ST_RUN   = 0;
    localparam int ST_VIEW  = 1;
    localparam int ST_LAST  = 2;
    localparam int ST_FULL0 = 3;
    localparam int ST_FULL1 = 4;
    localparam int ST_PEND  = 5;
    localparam int ST_OVF   = 6;
    localparam int ST_TRUNC = 7;

    // Events passed from the fill engine to the register
    typedef struct packed {
        logic done;   // a frame finished this cycle
        logic bank;   // bank that received it
        logic trunc;  // frame exceeded the bank size
        logic drop;   // frame discarded, no bank free
    } fill_evt_t;

    // Register state
    typedef struct packed {
        logic       run;
        logic       view;
        logic       last;
        logic       pend;
        logic       ovf;
        logic       trunc;
        logic [1:0] full;
    } csr_t;

endpackage

// File: rtl/pp_rx_bank.sv
module pp_rx_bank #(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
        rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/pp_rx_fill.sv
module pp_rx_fill
    import pp_rx_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid_i,
    input  logic          rx_sof_i,
    input  logic          rx_eof_i,
    input  logic          run_i,
    input  logic [1:0]    full_i,
    output logic          we_o,
    output logic          wbank_o,
    output logic [AW-1:0] waddr_o,
    output fill_evt_t     evt_o
);

    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    typedef struct packed {
        logic        active;
        logic        bank;
        logic [AW:0] off;
        logic        trunc;
        logic        pref;
    } fill_t;

    fill_t     f_d, f_q;
    fill_evt_t evt_d;
    logic      we_d;
    logic [AW-1:0] waddr_d;
    logic      ok_d;
    logic      tgt_d;

    always_comb begin
        f_d     = f_q;
        evt_d   = '0;
        we_d    = 1'b0;
        waddr_d = '0;
        ok_d    = 1'b0;
        tgt_d   = f_q.pref;
        if (rx_valid_i) begin
            if (rx_sof_i) begin
                if (run_i) begin
                    if (!full_i[f_q.pref]) begin
                        ok_d  = 1'b1;
                        tgt_d = f_q.pref;
                    end else if (!full_i[~f_q.pref]) begin
                        ok_d  = 1'b1;
                        tgt_d = ~f_q.pref;
                    end
                    if (ok_d) begin
                        we_d     = 1'b1;
                        f_d.bank = tgt_d;
                        f_d.active = 1'b1;
                        f_d.off  = (AW+1)'(1);
                        f_d.trunc = 1'b0;
                    end else begin
                        evt_d.drop = 1'b1;
                        f_d.active = 1'b0;
                    end
                end else begin
                    f_d.active = 1'b0;
                end
            end else if (f_q.active) begin
                if (f_q.off < DEPTH_V) begin
                    we_d    = 1'b1;
                    waddr_d = f_q.off[AW-1:0];
                    f_d.off = f_q.off + (AW+1)'(1);
                end else begin
                    f_d.trunc = 1'b1;
                end
            end
            if (rx_eof_i && f_d.active) begin
                evt_d.done  = 1'b1;
                evt_d.bank  = f_d.bank;
                evt_d.trunc = f_d.trunc;
                f_d.active  = 1'b0;
                f_d.pref    = ~f_d.bank;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign we_o    = we_d;
    assign wbank_o = f_d.bank;
    assign waddr_o = waddr_d;
    assign evt_o   = evt_d;

    // R7
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> !full_i[wbank_o]);

    // R8
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.drop |-> (full_i == 2'b11));

    // R2
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_sof_i && !run_i) |-> (!we_o && !evt_o.drop && !evt_o.done));

    // R5
    pref_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.done |=> (f_q.pref != $past(evt_o.bank)));

endmodule

// File: rtl/pp_rx_csr.sv
module pp_rx_csr
    import pp_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      reg_wr_i,
    input  logic [1:0] reg_wbits_i,
    input  fill_evt_t evt_i,
    output csr_t      csr_o
);

    csr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (reg_wr_i) begin
            c_d.run   = reg_wbits_i[0];
            c_d.view  = reg_wbits_i[1];
            c_d.pend  = 1'b0;
            c_d.ovf   = 1'b0;
            c_d.trunc = 1'b0;
            c_d.full[~reg_wbits_i[1]] = 1'b0;
        end
        if (evt_i.done) begin
            c_d.full[evt_i.bank] = 1'b1;
            c_d.last = evt_i.bank;
            c_d.pend = 1'b1;
            if (evt_i.trunc) c_d.trunc = 1'b1;
        end
        if (evt_i.drop) c_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign csr_o = c_q;

    // R4
    frame_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.done |=> (c_q.pend && (c_q.last == $past(evt_i.bank)) && c_q.full[$past(evt_i.bank)]));

    // R6
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !evt_i.done && !evt_i.drop) |=> (!c_q.pend && !c_q.ovf && !c_q.trunc));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !evt_i.done) |=> !c_q.full[~$past(reg_wbits_i[1])]);

    // R8
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.drop |=> c_q.ovf);

endmodule

// File: rtl/pp_rx_buffer.sv
module pp_rx_buffer
    import pp_rx_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    localparam int AW = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic [AW-1:0] buf_addr,
    output logic [7:0]    buf_rdata,
    output logic          irq
);

    csr_t          csr;
    fill_evt_t     evt;
    logic          we;
    logic          wbank;
    logic [AW-1:0] waddr;
    logic [7:0]    bank_rdata [2];
    logic          sel_d, sel_q;
    logic          wdata_unused;

    assign wdata_unused = ^reg_wdata[7:2];

    pp_rx_fill #(.DEPTH(BUF_BYTES)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid_i(rx_valid),
        .rx_sof_i  (rx_sof),
        .rx_eof_i  (rx_eof),
        .run_i     (csr.run),
        .full_i    (csr.full),
        .we_o      (we),
        .wbank_o   (wbank),
        .waddr_o   (waddr),
        .evt_o     (evt)
    );

    pp_rx_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_i   (reg_wr),
        .reg_wbits_i(reg_wdata[1:0]),
        .evt_i      (evt),
        .csr_o      (csr)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pp_rx_bank #(.DEPTH(BUF_BYTES)) u_bank (
            .clk    (clk),
            .we_i   (we && (wbank == 1'(b))),
            .waddr_i(waddr),
            .wdata_i(rx_data),
            .raddr_i(buf_addr),
            .rdata_o(bank_rdata[b])
        );
    end

    // Read select follows the data by one clock, like the bank read
    always_comb sel_d = csr.view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_d;
    end

    assign buf_rdata = sel_q ? bank_rdata[1] : bank_rdata[0];

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[ST_RUN]   = csr.run;
        reg_rdata[ST_VIEW]  = csr.view;
        reg_rdata[ST_LAST]  = csr.last;
        reg_rdata[ST_FULL0] = csr.full[0];
        reg_rdata[ST_FULL1] = csr.full[1];
        reg_rdata[ST_PEND]  = csr.pend;
        reg_rdata[ST_OVF]   = csr.ovf;
        reg_rdata[ST_TRUNC] = csr.trunc;
    end

    assign irq = csr.pend;

    // R10
    same_cycle_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && evt.done) |=> (irq && reg_rdata[ST_PEND]));

endmodule

// File: tb/sim_pp_rx_buffer.sv
module sim_pp_rx_buffer;

    localparam int BUF_BYTES = 2048;
    localparam int AW = $clog2(BUF_BYTES);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_sof = 1'b0;
    logic          rx_eof = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] buf_addr = '0;
    logic [7:0]    buf_rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    pp_rx_buffer #(.BUF_BYTES(BUF_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .irq(irq)
    );

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + i[7:0] + i[15:8];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic reg_write(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Sends n bytes; optionally writes the register on the last beat
    task automatic send_frame(input logic [7:0] seed, input int n,
                              input bit wr_on_eof, input logic [7:0] wv);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(seed, i);
            rx_sof   = (i == 0);
            rx_eof   = (i == n - 1);
            if (wr_on_eof && i == n - 1) begin
                reg_wr = 1'b1;
                reg_wdata = wv;
            end
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof = 1'b0;
        rx_eof = 1'b0;
        reg_wr = 1'b0;
    endtask

    task automatic read_byte(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = AW'(a);
        @(posedge clk);
        @(negedge clk);
        d = buf_rdata;
    endtask

    task automatic t_reset();
        check("R1", "status after reset", reg_rdata, 8'h00);
        check("R1", "irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_run_off();
        send_frame(8'h55, 3, 1'b0, 8'h00);
        check("R2", "status with receiver off", reg_rdata, 8'h00);
        reg_write(8'h01);
        check("R2", "enable bit set", reg_rdata, 8'h01);
    endtask

    task automatic t_first_frame();
        logic [7:0] d;
        send_frame(8'h10, 4, 1'b0, 8'h00);
        check("R4", "status after first frame", reg_rdata, 8'h29);
        check("R4", "irq after first frame", {7'b0, irq}, 8'h01);
        for (int i = 0; i < 4; i++) begin
            read_byte(i, d);
            check("R3", $sformatf("bank0 byte %0d", i), d, pat(8'h10, i));
        end
    endtask

    task automatic t_second_and_drop();
        logic [7:0] d;
        send_frame(8'h40, 3, 1'b0, 8'h00);
        check("R5", "second frame in bank1", reg_rdata, 8'h3D);
        send_frame(8'hC0, 2, 1'b0, 8'h00);
        check("R8", "overflow when both occupied", reg_rdata, 8'h7D);
        read_byte(0, d);
        check("R8", "bank0 kept after drop", d, 8'h10);
    endtask

    task automatic t_ack_view();
        logic [7:0] d;
        reg_write(8'h03);
        check("R6", "status after ack view1", reg_rdata, 8'h17);
        check("R6", "irq cleared", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 3; i++) begin
            read_byte(i, d);
            check("R3", $sformatf("bank1 byte %0d", i), d, pat(8'h40, i));
        end
    endtask

    task automatic t_single_byte();
        logic [7:0] d;
        send_frame(8'h77, 1, 1'b0, 8'h00);
        check("R11", "one-byte frame status", reg_rdata, 8'h3B);
        reg_write(8'h01);
        check("R6", "release bank1", reg_rdata, 8'h09);
        read_byte(0, d);
        check("R11", "one-byte frame content", d, 8'h77);
    endtask

    task automatic t_fallback();
        logic [7:0] d;
        send_frame(8'h90, 2, 1'b0, 8'h00);
        check("R5", "frame into bank1", reg_rdata, 8'h3D);
        reg_write(8'h01);
        check("R6", "bank1 released, bank0 held", reg_rdata, 8'h0D);
        send_frame(8'hA0, 2, 1'b0, 8'h00);
        check("R7", "fallback to free bank1", reg_rdata, 8'h3D);
        read_byte(0, d);
        check("R7", "held bank0 not overwritten", d, 8'h77);
        reg_write(8'h03);
        check("R6", "view1 releases bank0", reg_rdata, 8'h17);
        read_byte(0, d);
        check("R7", "fallback frame byte0", d, 8'hA0);
        read_byte(1, d);
        check("R7", "fallback frame byte1", d, 8'hA1);
    endtask

    task automatic t_same_cycle();
        send_frame(8'h33, 2, 1'b1, 8'h03);
        check("R10", "completion wins over write", reg_rdata, 8'h3B);
        check("R10", "irq stays high", {7'b0, irq}, 8'h01);
        reg_write(8'h01);
        check("R6", "release bank1 again", reg_rdata, 8'h09);
    endtask

    task automatic t_truncate();
        logic [7:0] d;
        send_frame(8'h05, BUF_BYTES + 2, 1'b0, 8'h00);
        check("R9", "truncated frame status", reg_rdata, 8'hBD);
        reg_write(8'h03);
        check("R9", "truncation flag cleared by write", reg_rdata, 8'h17);
        read_byte(0, d);
        check("R9", "byte0 not wrapped", d, pat(8'h05, 0));
        read_byte(1, d);
        check("R9", "byte1 not wrapped", d, pat(8'h05, 1));
        read_byte(BUF_BYTES - 1, d);
        check("R9", "last stored byte", d, pat(8'h05, BUF_BYTES - 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_off();
        t_first_frame();
        t_second_and_drop();
        t_ack_view();
        t_single_byte();
        t_fallback();
        t_same_cycle();
        t_truncate();
        done_flag = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule